// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block sits next to the transmit and receive frame engines of a serial port that carries a time-division multiplexed stream. For every word slot of a frame it says whether that slot is taken part in: whether the transmitter drives the slot, or whether the receiver hands the slot's word on to the host. The two directions are fully separate. Each has its own control register, its own set of eight 16-bit channel-enable registers, its own frame-sync input and its own word-boundary strobe.

Each direction has three ways to select slots. With multichannel selection off, every slot is enabled. In the 32-channel compatibility mode, two partitions each point at one 16-slot block: partition A at an even block and partition B at an odd block. Two enable registers then mask the slots inside those blocks. In the 128-channel extended mode, each of the 128 slots has its own enable bit. Software writes the shadow registers at any time. A frame sync copies them into the working set, so a frame never changes its selection pattern partway through.

Top module: `tdm_slot_sel`

## Requirements
- R1: After reset, every register reads 0, and both `tx_slot_en` and `rx_slot_en` are 1.
- R2: When control bit 0 (multichannel enable) of the working set is 0, every slot of that direction is enabled, including slots beyond 127.
- R3: A direction's slot counter becomes 0 on the clock after its frame sync. It rises by one on the clock after each word strobe and saturates at 255. A frame sync in the same cycle as a word strobe wins. Control bits 4:2 read back the counter's bits 6:4 and cannot be written.
- R4: Compatibility mode applies when control bit 9 is 0 and bit 0 is 1. An even block 2a is enabled when control bits 6:5 equal a; the slot then takes bit (slot mod 16) of enable register 0. An odd block 2b+1 is enabled when bits 8:7 equal b; the slot then takes the same bit of enable register 1. Enable registers 2 to 7 have no effect in this mode.
- R5: Extended mode applies when bit 9 and bit 0 are both 1. Slot s then takes bit (s mod 16) of enable register (s div 16).
- R6: When multichannel selection is on, in either mode, slots 128 and above are disabled.
- R7: A register write shows on readback in the next cycle. It changes slot selection only from the next frame sync of that direction.
- R8: Register address bit 4 picks the direction (0 transmit, 1 receive). Bits 3:0 pick the register: 0 is control, 1 to 8 are enable registers 0 to 7. The two directions hold and apply their settings independently.
- R9: Control bits 15:10 read 0. In the receive control register bit 1 also reads 0. In the transmit control register bit 1 is stored and read back but has no effect on selection.
- R10: Register indices 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 1 | Transmit word-boundary strobe |
| rx_fsync | input | 1 | Receive frame sync |
| rx_word | input | 1 | Receive word-boundary strobe |
| tx_slot_en | output | 1 | Current transmit slot is enabled |
| rx_slot_en | output | 1 | Current receive slot is enabled |

## Verification
A frame sync and a word strobe can land in the same cycle. The frame sync must win, so the counter goes to 0 and the new working set loads, rather than the counter stepping forward. The bench advances a frame to slot 40, which lies in block 2. It then raises both strobes together and checks that the block field reads 0 and that the slot enable equals the model's value for slot 0 under the newly loaded settings. A second pairing, a register write that arrives in the middle of a frame, is judged the same way: the output stays on the old pattern, while readback shows the new value at once.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
    localparam int BLK_W     = 16;
    localparam int NBLK      = 8;
    localparam int SLOT_W    = 8;
    localparam int BLK_IDX_W = $clog2(NBLK);
    localparam int BIT_IDX_W = $clog2(BLK_W);
    localparam int PART_W    = $clog2(NBLK / 2);
    localparam int SLOT_LIM  = NBLK * BLK_W;

    typedef struct packed {
        logic                           mcm;
        logic                           spare;
        logic                           ext;
        logic [PART_W-1:0]              pa;
        logic [PART_W-1:0]              pb;
        logic [NBLK-1:0][BLK_W-1:0]     en;
    } sel_cfg_t;

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        sel_cfg_t          act;
    } eng_state_t;
endpackage

// File: rtl/tdm_sel_regs.sv
module tdm_sel_regs
    import tdm_sel_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [BLK_W-1:0] wdata,
    output sel_cfg_t         cfg
);
    sel_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (idx == '0) begin
                cfg_d.mcm   = wdata[0];
                cfg_d.spare = IS_RX ? 1'b0 : wdata[1];
                cfg_d.pa    = wdata[5 +: PART_W];
                cfg_d.pb    = wdata[7 +: PART_W];
                cfg_d.ext   = wdata[9];
            end
            for (int k = 0; k < NBLK; k++) begin
                if (idx == IDX_W'(k + 1)) cfg_d.en[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R9: receive bit 1 never holds a one
    a_r9_rx_bit1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        IS_RX |-> !cfg_q.spare);
    // R7/R10: without a write strobe the shadow set keeps its value
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cfg_q));
endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine
    import tdm_sel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic                 word,
    input  sel_cfg_t             shadow,
    output logic                 slot_en,
    output logic [BLK_IDX_W-1:0] cur_blk
);
    eng_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync) begin
            st_d.cnt = '0;
            st_d.act = shadow;
        end else if (word && (st_q.cnt != '1)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [BLK_IDX_W-1:0] blk;
    logic [BIT_IDX_W-1:0] bitpos;
    logic                 beyond, part_hit, leg_bit, ext_bit;

    always_comb begin
        blk      = st_q.cnt[BIT_IDX_W +: BLK_IDX_W];
        bitpos   = st_q.cnt[BIT_IDX_W-1:0];
        beyond   = st_q.cnt >= SLOT_W'(SLOT_LIM);
        part_hit = blk[0] ? (blk[BLK_IDX_W-1:1] == st_q.act.pb)
                          : (blk[BLK_IDX_W-1:1] == st_q.act.pa);
        leg_bit  = blk[0] ? st_q.act.en[1][bitpos] : st_q.act.en[0][bitpos];
        ext_bit  = st_q.act.en[blk][bitpos];
        slot_en  = !st_q.act.mcm ||
                   (!beyond && (st_q.act.ext ? ext_bit : (part_hit && leg_bit)));
    end

    assign cur_blk = blk;

    a_r3_fsync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> st_q.cnt == '0);
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && word && st_q.cnt != '1) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && st_q.cnt == '1) |=> st_q.cnt == '1);
    a_r7_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> $stable(st_q.act));
    a_r6_beyond_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act.mcm && beyond) |-> !slot_en);
    a_r2_bypass_on: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.act.mcm |-> slot_en);
endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel
    import tdm_sel_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BLK_W-1:0]  reg_wdata,
    output logic [BLK_W-1:0]  reg_rdata,
    input  logic              tx_fsync,
    input  logic              tx_word,
    input  logic              rx_fsync,
    input  logic              rx_word,
    output logic              tx_slot_en,
    output logic              rx_slot_en
);
    localparam int IDX_W = ADDR_W - 1;
    localparam int NDIR  = 2;

    logic [IDX_W-1:0]     idx;
    logic                 dir;
    logic [NDIR-1:0]      fs_v, wd_v, en_v;
    sel_cfg_t             cfg_v [NDIR];
    logic [BLK_IDX_W-1:0] blk_v [NDIR];

    assign idx  = reg_addr[IDX_W-1:0];
    assign dir  = reg_addr[ADDR_W-1];
    assign fs_v = {rx_fsync, tx_fsync};
    assign wd_v = {rx_word, tx_word};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        tdm_sel_regs #(.IS_RX(d == 1), .IDX_W(IDX_W)) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr && (dir == 1'(d))),
            .idx   (idx),
            .wdata (reg_wdata),
            .cfg   (cfg_v[d])
        );
        tdm_slot_engine u_eng (
            .clk     (clk),
            .rst_n   (rst_n),
            .fsync   (fs_v[d]),
            .word    (wd_v[d]),
            .shadow  (cfg_v[d]),
            .slot_en (en_v[d]),
            .cur_blk (blk_v[d])
        );
    end

    assign tx_slot_en = en_v[0];
    assign rx_slot_en = en_v[1];

    always_comb begin
        sel_cfg_t c;
        c = cfg_v[dir];
        reg_rdata = '0;
        if (idx == '0) begin
            reg_rdata = {6'b0, c.ext, c.pb, c.pa, blk_v[dir], c.spare, c.mcm};
        end
        for (int k = 0; k < NBLK; k++) begin
            if (idx == IDX_W'(k + 1)) reg_rdata = c.en[k];
        end
    end

    // R10: unmapped indices read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idx > IDX_W'(NBLK)) |-> reg_rdata == '0);
endmodule

// File: tb/tdm_slot_sel_tb.sv
module tdm_slot_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_fsync = 1'b0, tx_word = 1'b0, rx_fsync = 1'b0, rx_word = 1'b0;
    logic        tx_slot_en, rx_slot_en;

    int vec = 0;
    int bad = 0;

    logic [15:0] sh_en [2][8];
    logic [15:0] ac_en [2][8];
    logic        sh_mcm [2], sh_ext [2], ac_mcm [2], ac_ext [2];
    logic [1:0]  sh_pa [2], sh_pb [2], ac_pa [2], ac_pb [2];
    logic        sh_sp;

    always #5 clk = ~clk;

    tdm_slot_sel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_fsync(tx_fsync), .tx_word(tx_word), .rx_fsync(rx_fsync), .rx_word(rx_word),
        .tx_slot_en(tx_slot_en), .rx_slot_en(rx_slot_en)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_en(int d, int s);
        int t = (s > 255) ? 255 : s;
        int b = t / 16;
        int p = t % 16;
        if (!ac_mcm[d]) return 1'b1;
        if (t >= 128) return 1'b0;
        if (ac_ext[d]) return ac_en[d][b][p];
        if (b % 2 == 0) return (b / 2 == int'(ac_pa[d])) && ac_en[d][0][p];
        return (b / 2 == int'(ac_pb[d])) && ac_en[d][1][p];
    endfunction

    function automatic logic [15:0] exp_ctrl(int d, int blk);
        return {6'b0, sh_ext[d], sh_pb[d], sh_pa[d], 3'(blk), (d == 0) ? sh_sp : 1'b0, sh_mcm[d]};
    endfunction

    task automatic wr(int a, logic [15:0] v);
        int d = (a >> 4) & 1;
        int i = a & 15;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (i == 0) begin
            sh_mcm[d] = v[0]; sh_pa[d] = v[6:5]; sh_pb[d] = v[8:7]; sh_ext[d] = v[9];
            if (d == 0) sh_sp = v[1];
        end else if (i <= 8) begin
            sh_en[d][i-1] = v;
        end
    endtask

    task automatic rd(string req, int a, logic [15:0] exp);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic load_active();
        for (int d = 0; d < 2; d++) begin
            ac_mcm[d] = sh_mcm[d]; ac_ext[d] = sh_ext[d];
            ac_pa[d] = sh_pa[d]; ac_pb[d] = sh_pb[d];
            for (int k = 0; k < 8; k++) ac_en[d][k] = sh_en[d][k];
        end
    endtask

    task automatic fs();
        @(negedge clk);
        tx_fsync = 1'b1; rx_fsync = 1'b1; tx_word = 1'b0; rx_word = 1'b0;
        load_active();
        @(negedge clk);
        tx_fsync = 1'b0; rx_fsync = 1'b0;
    endtask

    // Called at a negedge with counters at 0; checks slots 0..n-1, ends with counters at n.
    task automatic sweep(string req, int n);
        reg_addr = 5'd0;
        for (int s = 0; s < n; s++) begin
            int t = (s > 255) ? 255 : s;
            #1;
            chk(req, {15'b0, tx_slot_en}, {15'b0, exp_en(0, s)});
            chk(req, {15'b0, rx_slot_en}, {15'b0, exp_en(1, s)});
            chk("R3", reg_rdata, exp_ctrl(0, (t >> 4) & 7));
            tx_word = 1'b1; rx_word = 1'b1;
            @(negedge clk);
        end
        tx_word = 1'b0; rx_word = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            sh_mcm[d] = 0; sh_ext[d] = 0; sh_pa[d] = 0; sh_pb[d] = 0;
            for (int k = 0; k < 8; k++) sh_en[d][k] = '0;
        end
        sh_sp = 0;
        load_active();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 32; a++) rd("R1", a, 16'h0);
        chk("R1", {15'b0, tx_slot_en}, 16'h1);
        chk("R1", {15'b0, rx_slot_en}, 16'h1);

        // R2: bypass, including beyond 127 and saturation
        wr(5'h01, 16'h0000);
        fs();
        sweep("R2", 260);

        // R4: legacy partition sweep; extended registers loaded but ignored
        for (int k = 2; k < 8; k++) begin
            wr(k + 1, 16'hFFFF);
            wr(16 + k + 1, 16'hFFFF);
        end
        for (int pa = 0; pa < 4; pa++) begin
            for (int pb = 0; pb < 4; pb++) begin
                wr(5'h00, 16'(1 | ((pa & 1) << 1) | (pa << 5) | (pb << 7)));
                wr(5'h01, 16'hF0F0 ^ 16'(pa * 16'h0F11));
                wr(5'h02, 16'h3C5A + 16'(pb));
                wr(5'h10, 16'(1 | ((3 - pa) << 5) | ((3 - pb) << 7)));
                wr(5'h11, ~(16'hF0F0 ^ 16'(pa * 16'h0F11)));
                wr(5'h12, 16'hA55A ^ 16'(pb << 4));
                fs();
                sweep("R4", 130);
            end
        end

        // R5/R6/R8: extended mode, distinct per direction
        for (int k = 0; k < 8; k++) begin
            wr(k + 1, 16'hA5A5 ^ 16'(k * 16'h1357));
            wr(16 + k + 1, 16'hFFFF);
        end
        wr(5'h00, 16'h0201);
        wr(5'h10, 16'h0201);
        fs();
        sweep("R5", 260);

        // R7: mid-frame writes leave the running frame alone
        wr(5'h01, 16'hFFFF);
        fs();
        sweep("R7", 3);
        wr(5'h01, 16'h0000);
        wr(5'h00, 16'h0000);
        #1;
        chk("R7", {15'b0, tx_slot_en}, 16'h1);
        rd("R7", 5'h01, 16'h0000);
        wr(5'h00, 16'h0201);
        #1;
        chk("R7", {15'b0, tx_slot_en}, {15'b0, exp_en(0, 3)});
        fs();
        sweep("R7", 20);

        // R3: frame sync and word strobe together
        fs();
        sweep("R3", 40);
        @(negedge clk);
        tx_fsync = 1'b1; rx_fsync = 1'b1; tx_word = 1'b1; rx_word = 1'b1;
        load_active();
        @(negedge clk);
        tx_fsync = 1'b0; rx_fsync = 1'b0; tx_word = 1'b0; rx_word = 1'b0;
        reg_addr = 5'd0;
        #1;
        chk("R3", reg_rdata, exp_ctrl(0, 0));
        chk("R3", {15'b0, tx_slot_en}, {15'b0, exp_en(0, 0)});
        chk("R3", {15'b0, rx_slot_en}, {15'b0, exp_en(1, 0)});

        // R9: reserved control bits
        wr(5'h00, 16'hFFFF);
        wr(5'h10, 16'hFFFF);
        fs();
        rd("R9", 5'h00, 16'h03E3);
        rd("R9", 5'h10, 16'h03E1);
        wr(5'h00, 16'h0203);
        fs();
        sweep("R9", 130);

        // R10: unmapped indices
        for (int i = 9; i < 16; i++) begin
            wr(i, 16'hFFFF);
            wr(16 + i, 16'hFFFF);
        end
        for (int i = 9; i < 16; i++) begin
            rd("R10", i, 16'h0);
            rd("R10", 16 + i, 16'h0);
        end
        for (int k = 0; k < 8; k++) begin
            rd("R10", k + 1, sh_en[0][k]);
            rd("R8", 16 + k + 1, sh_en[1][k]);
        end
        rd("R10", 5'h00, exp_ctrl(0, 0));
        rd("R8", 5'h10, exp_ctrl(1, 0));

        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule